// File: doc/BRIEF.md
# Three-Wire Serial Configuration Receiver

This block receives configuration words over a three-wire serial link made of a serial clock, a serial data line and a load strobe. All three lines are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the system clock domain. On every rising edge of the serial clock, one data bit enters a 24-bit shift register, with the most significant bit arriving first. A rising edge on the load strobe commits the assembled word to one of four held control registers. The two least significant bits of the word choose the register, and the remaining 22 bits are the payload that gets stored.

The four registers are the reference divider register, the feedback divider register, the mode register and the startup register. Writing the startup register also copies the same payload into the mode register and emits a one-cycle counter-reset pulse. Each accepted commit emits a one-cycle update strobe together with the selector that was used. A strobe that arrives when the number of bits shifted since the previous strobe is not exactly 24 is discarded and raises a one-cycle error pulse.

A four-state frame machine drives the transfer. The states and their transitions are:

- Idle (no bits yet): a serial-clock rise moves it to Shifting.
- Shifting: bits are counted. The rise that brings the count to 24 moves it to Full.
- Full: exactly 24 bits are present. A strobe commits the word. A further serial-clock rise moves it to Overrun.
- Overrun: more than 24 bits have arrived.
- From every state, a strobe returns the machine to Idle. It commits only from Full and flags an error from any other state.
- If a strobe edge and a serial-clock edge are seen in the same cycle, the strobe takes priority and that bit is dropped.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset all four held registers, both divider fields and the outputs upd_valid, cnt_rst and frame_err are zero.
- R2: Bits are taken on serial-clock rising edges, most significant first. After 24 bits, word bit 23 is the first bit sent and bit 0 is the last; the payload is bits 23..2.
- R3: On a valid strobe, control bits (word bits 1..0) select the target: 00 reference register, 01 feedback register, 10 mode register, 11 startup register. Registers not targeted keep their value.
- R4: Selector 11 writes the payload into both the startup and the mode register and pulses cnt_rst for exactly one cycle. Other selectors never pulse cnt_rst.
- R5: A strobe after a bit count other than 24 (including zero or more than 24) changes no register, produces no update strobe and pulses frame_err for one cycle.
- R6: Each accepted commit pulses upd_valid for exactly one cycle, with upd_sel equal to the word's control bits.
- R7: ref_div is word bits 15..2 of the reference register (14 bits). n_div is word bits 20..8 of the feedback register (13 bits).
- R8: Every strobe, accepted or not, restarts bit counting, so the next 24 bits form a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| le_in | input | 1 | Load strobe, asynchronous |
| ref_word | output | 22 | Reference divider register payload |
| n_word | output | 22 | Feedback divider register payload |
| func_word | output | 22 | Mode register payload |
| init_word | output | 22 | Startup register payload |
| ref_div | output | 14 | Reference divide value field |
| n_div | output | 13 | Feedback divide value field |
| upd_valid | output | 1 | One-cycle pulse per accepted commit |
| upd_sel | output | 2 | Selector of the latest commit |
| cnt_rst | output | 1 | One-cycle pulse on a startup register write |
| frame_err | output | 1 | One-cycle pulse on a rejected strobe |

## Verification
The hardest situations to reach are the wrong-length frames. One is a strobe with no bits at all. Another is a frame of 25 or more bits, which has passed through Full into Overrun. A third is the first good word right after such a rejection, which shows that counting restarted. The bench's word-sending task takes an explicit bit count, so it can produce short, empty and over-long frames at will. It then interleaves them with a sweep over all four selectors and several arithmetically generated payloads, and tracks the expected register contents and pulse counts after every strobe.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

    typedef enum logic [1:0] {
        SEL_REF  = 2'b00,
        SEL_NCNT = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_OVER
    } fr_state_e;

    localparam int NUM_TARGETS = 4;

endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    // pipe[STAGES-1] is the synchronized level; pipe[STAGES] is its history
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/cfg_frame_ctrl.sv
module cfg_frame_ctrl
    import cfg_serial_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              bit_val,
    input  logic              strobe_rise,
    output logic [WORD_W-1:0] word_q,
    output logic              commit,
    output logic              frame_err
);
    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(WORD_W - 1);

    fr_state_e       state, state_nx;
    logic [CW-1:0]   cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (strobe_rise)   state_nx = ST_IDLE;
                else if (bit_rise) state_nx = (WORD_W == 1) ? ST_FULL : ST_SHIFT;
            end
            ST_SHIFT: begin
                if (strobe_rise)                       state_nx = ST_IDLE;
                else if (bit_rise && cnt == LAST_CNT)  state_nx = ST_FULL;
            end
            ST_FULL: begin
                if (strobe_rise)   state_nx = ST_IDLE;
                else if (bit_rise) state_nx = ST_OVER;
            end
            ST_OVER: begin
                if (strobe_rise)   state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign commit = strobe_rise && (state == ST_FULL);

    // outputs: bit counter, shift register, error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            word_q    <= '0;
            frame_err <= 1'b0;
        end else begin
            frame_err <= strobe_rise && (state != ST_FULL);
            if (strobe_rise) begin
                cnt <= '0;
            end else if (bit_rise) begin
                word_q <= {word_q[WORD_W-2:0], bit_val};
                if (state == ST_IDLE || state == ST_SHIFT)
                    cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(WORD_W)); // R5

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0)); // R8

    AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> (state == ST_IDLE)); // R8
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
    import cfg_serial_pkg::*;
#(
    parameter int PAY_W = 22
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit,
    input  logic [1:0]                         sel,
    input  logic [PAY_W-1:0]                   payload,
    output logic [NUM_TARGETS-1:0][PAY_W-1:0]  lat_q,
    output logic                               upd_valid,
    output logic [1:0]                         upd_sel,
    output logic                               cnt_rst
);
    for (genvar g = 0; g < NUM_TARGETS; g++) begin : g_lat
        logic hit;
        assign hit = commit && ((sel == 2'(g)) ||
                     ((2'(g) == 2'(SEL_FUNC)) && (sel == 2'(SEL_INIT))));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   lat_q[g] <= '0;
            else if (hit) lat_q[g] <= payload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_sel   <= 2'b00;
            cnt_rst   <= 1'b0;
        end else begin
            upd_valid <= commit;
            cnt_rst   <= commit && (sel == 2'(SEL_INIT));
            if (commit) upd_sel <= sel;
        end
    end

    AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> $stable(lat_q)); // R3

    AST_INIT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_sel == 2'(SEL_INIT)) |-> (lat_q[2'(SEL_FUNC)] == lat_q[2'(SEL_INIT)])); // R4

    AST_RST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |-> (upd_valid && upd_sel == 2'(SEL_INIT))); // R4

    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid); // R6
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
    import cfg_serial_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int REF_DIV_W   = 14,
    parameter int REF_DIV_LSB = 2,
    parameter int N_DIV_W     = 13,
    parameter int N_DIV_LSB   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_in,
    input  logic                 sdata_in,
    input  logic                 le_in,
    output logic [WORD_W-3:0]    ref_word,
    output logic [WORD_W-3:0]    n_word,
    output logic [WORD_W-3:0]    func_word,
    output logic [WORD_W-3:0]    init_word,
    output logic [REF_DIV_W-1:0] ref_div,
    output logic [N_DIV_W-1:0]   n_div,
    output logic                 upd_valid,
    output logic [1:0]           upd_sel,
    output logic                 cnt_rst,
    output logic                 frame_err
);
    localparam int PAY_W  = WORD_W - 2;
    localparam int N_LINE = 3;

    logic [N_LINE-1:0] raw_in, lvl, rise;
    assign raw_in = {le_in, sdata_in, sclk_in};

    for (genvar i = 0; i < N_LINE; i++) begin : g_sync
        cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[i]),
            .level (lvl[i]),
            .rise  (rise[i])
        );
    end

    logic [WORD_W-1:0] word_q;
    logic              commit;

    cfg_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_rise    (rise[0]),
        .bit_val     (lvl[1]),
        .strobe_rise (rise[2]),
        .word_q      (word_q),
        .commit      (commit),
        .frame_err   (frame_err)
    );

    logic [NUM_TARGETS-1:0][PAY_W-1:0] lat_q;

    cfg_latch_bank #(.PAY_W(PAY_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .sel       (word_q[1:0]),
        .payload   (word_q[WORD_W-1:2]),
        .lat_q     (lat_q),
        .upd_valid (upd_valid),
        .upd_sel   (upd_sel),
        .cnt_rst   (cnt_rst)
    );

    assign ref_word  = lat_q[2'(SEL_REF)];
    assign n_word    = lat_q[2'(SEL_NCNT)];
    assign func_word = lat_q[2'(SEL_FUNC)];
    assign init_word = lat_q[2'(SEL_INIT)];
    assign ref_div   = ref_word[REF_DIV_LSB-2 +: REF_DIV_W];
    assign n_div     = n_word[N_DIV_LSB-2 +: N_DIV_W];

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && upd_valid)); // R5

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err); // R5
endmodule

// File: tb/sim_cfg_serial_rx.sv
module sim_cfg_serial_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0, sdata_in = 1'b0, le_in = 1'b0;
    logic [21:0] ref_word, n_word, func_word, init_word;
    logic [13:0] ref_div;
    logic [12:0] n_div;
    logic upd_valid, cnt_rst, frame_err;
    logic [1:0] upd_sel;

    always #10 clk = ~clk;

    cfg_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in), .le_in(le_in),
        .ref_word(ref_word), .n_word(n_word), .func_word(func_word), .init_word(init_word),
        .ref_div(ref_div), .n_div(n_div), .upd_valid(upd_valid), .upd_sel(upd_sel),
        .cnt_rst(cnt_rst), .frame_err(frame_err)
    );

    int nchk = 0, nerr = 0;
    int upd_cnt = 0, err_cnt = 0, rst_cnt = 0;
    logic [1:0] last_sel = 2'b00;
    bit done = 0;

    int exp_upd = 0, exp_err = 0, exp_rst = 0;
    logic [1:0] exp_sel = 2'b00;
    logic [21:0] exp_lat [4];

    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_valid) begin upd_cnt++; last_sel = upd_sel; end
            if (frame_err) err_cnt++;
            if (cnt_rst)   rst_cnt++;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [23:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdata_in = w[23 - (i % 24)];
            wait_clk(3);
            sclk_in = 1'b1;
            wait_clk(3);
            sclk_in = 1'b0;
            wait_clk(3);
        end
        wait_clk(2);
        le_in = 1'b1;
        wait_clk(3);
        le_in = 1'b0;
        wait_clk(6);
        if (nbits == 24) begin
            exp_lat[w[1:0]] = w[23:2];
            if (w[1:0] == 2'b11) begin exp_lat[2] = w[23:2]; exp_rst++; end
            exp_upd++;
            exp_sel = w[1:0];
        end else begin
            exp_err++;
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, "/R3"}, "ref_word",  ref_word,  exp_lat[0]);
        chk({tag, "/R3"}, "n_word",    n_word,    exp_lat[1]);
        chk({tag, "/R3"}, "func_word", func_word, exp_lat[2]);
        chk({tag, "/R4"}, "init_word", init_word, exp_lat[3]);
        chk({tag, "/R7"}, "ref_div",   ref_div,   exp_lat[0][13:0]);
        chk({tag, "/R7"}, "n_div",     n_div,     exp_lat[1][18:6]);
        chk({tag, "/R6"}, "upd count", upd_cnt,   exp_upd);
        chk({tag, "/R6"}, "upd_sel",   last_sel,  exp_sel);
        chk({tag, "/R5"}, "err count", err_cnt,   exp_err);
        chk({tag, "/R4"}, "cnt_rst count", rst_cnt, exp_rst);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) exp_lat[k] = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(3);
        // R1: reset state
        chk("R1", "upd_valid", upd_valid, 0);
        chk("R1", "cnt_rst", cnt_rst, 0);
        chk("R1", "frame_err", frame_err, 0);
        check_all("R1");

        // R2: ordering, distinct pattern to reference register
        send(24'hA5C3F0, 24);
        check_all("R2");

        // R3/R4/R6/R7: sweep selectors and payloads
        for (int k = 0; k < 6; k++) begin
            for (int s = 0; s < 4; s++) begin
                logic [21:0] pay;
                pay = 22'((k * 32'h2F5A3 + s * 32'h1B7) ^ 32'h155555);
                send({pay, 2'(s)}, 24);
                check_all("R3");
            end
        end

        // R5: wrong-length frames
        send(24'hFFFFFF, 0);  check_all("R5_zero");
        send(24'hFFFFFD, 1);  check_all("R5_one");
        send(24'h123457, 23); check_all("R5_short");
        send(24'h89ABCE, 25); check_all("R5_over");
        send(24'h456787, 30); check_all("R5_long");

        // R8: counting restarts after a rejected strobe
        send(24'hABCDE7, 10);
        send(24'h3C5A96, 24); check_all("R8_after_short");
        send(24'h0F0F0F, 27);
        send(24'h7E8181, 24); check_all("R8_after_over");
        send(24'h2468AC, 24); check_all("R8_back_to_back");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule